// File: doc/BRIEF.md
# Strided and Indexed Vector Memory Address Unit

This block sits between the lanes of a vector processor and a single data cache. It accepts one vector load or store at a time and produces one byte address per element. In strided mode an address is a base plus the element number times a signed byte stride. In indexed mode it is the base plus that element's own offset. Elements go out as request groups. Each group holds a fixed number of memory slots, so several element requests reach the cache in one cycle, and groups leave in element order.

The generated groups wait in a request queue. For stores, the steered data waits in a separate write queue that moves in lockstep with the request queue. A write crossbar picks each slot's data from the owning vector lane, places it on the byte lanes of the target word and sets the byte enables. Load responses come back in order, one word per slot. A read crossbar sends each word to the vector lane that owns it. On the way it extracts the byte or halfword and zero- or sign-extends it. The unit stays busy until the last store group has gone to the cache or the last load result has been written to its lane.

Top module: `vmem_addr_unit`

## Requirements
- R1: In strided mode (`indexed`=0), element e addresses `base + stride*e` modulo 2^32, where stride is a two's-complement byte distance.
- R2: In indexed mode (`indexed`=1), element e addresses `base + idx_flat[32e+31:32e]` modulo 2^32.
- R3: Group g carries elements 4g..4g+3 in slots 0..3. Slot s is bits [32s+31:32s] of `creq_addr_flat`, and `creq_mask[s]` is set exactly when 4g+s < `vlen`. Exactly ceil(`vlen`/4) groups are accepted, in increasing g.
- R4: Width code `ew` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements. Per slot, `creq_be_flat[4s+3:4s]` is 0001 shifted left by addr[1:0] for bytes, 0011 or 1100 by addr[1] for halves, and 1111 for words. Store data is the lane's low byte replicated 4 times, its low half replicated twice, or the full word.
- R5: For a load, slot s of the response word is shifted right by 8×addr[1:0] for bytes or 16×addr[1] for halves. It is zero-extended when `sext`=0 and sign-extended when `sext`=1, then written to `rd_data_flat` lane e with `rd_valid[e]` set. Lanes at or above `vlen` stay invalid.
- R6: While `creq_valid` is high and `creq_ready` is low, the request is held unchanged. Every group is delivered exactly once, whatever the stall pattern.
- R7: A `start` sampled while idle raises `busy` the next cycle and clears all `rd_valid` bits. A `start` while busy is ignored. `busy` falls one cycle after the last store group is accepted or the last load response arrives.
- R8: An instruction with `vlen`=0 issues no request, and `busy` falls one cycle after rising.
- R9: After reset, `busy`, `creq_valid` and every `rd_valid` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe, taken when idle |
| is_store | input | 1 | 1 = store, 0 = load |
| indexed | input | 1 | 1 = base+index addressing, 0 = strided |
| ew | input | 2 | Element width code (0 byte, 1 half, 2 word) |
| sext | input | 1 | Sign-extend loaded elements |
| vlen | input | 5 | Element count, 0..NLANES |
| base | input | 32 | Base byte address |
| stride | input | 32 | Signed byte stride |
| idx_flat | input | NLANES*32 | Per-element byte offsets |
| wdata_flat | input | NLANES*32 | Per-element store data |
| busy | output | 1 | Instruction in progress |
| creq_valid | output | 1 | Request group ready for the cache |
| creq_ready | input | 1 | Cache accepts the group (low = stall) |
| creq_write | output | 1 | Group is a store |
| creq_mask | output | MLANES | Active slots of the group |
| creq_addr_flat | output | MLANES*32 | Per-slot byte address |
| creq_be_flat | output | MLANES*4 | Per-slot byte enables |
| creq_wdata_flat | output | MLANES*32 | Per-slot steered store data |
| cresp_valid | input | 1 | In-order load response |
| cresp_data_flat | input | MLANES*32 | Per-slot response word |
| rd_valid | output | NLANES | Lane holds a loaded element |
| rd_data_flat | output | NLANES*32 | Per-lane extended load result |

## Verification
A wrong group counter or base accumulator shows at once on the next accepted group as a wrong slot address or mask. The scoreboard compares every handshake against an independently built expected group. A queue pointer that slips duplicates or drops a group under stall. That shows either as an unexpected request or as a non-empty expected queue when `busy` falls. A read crossbar that routes or extends wrongly shows only after the instruction ends, so every lane value and valid bit is checked then. This includes lanes above `vlen`, which must stay invalid.

// File: rtl/vmau_pkg.sv
package vmau_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  // byte enables for one element at byte offset off
  function automatic logic [BE_W-1:0] elem_be(input logic [1:0] ew, input logic [1:0] off);
    case (ew)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // replicate the element across the word so any offset sees it
  function automatic logic [WORD_W-1:0] elem_wr(input logic [1:0] ew, input logic [WORD_W-1:0] d);
    case (ew)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // extract and extend a loaded element
  function automatic logic [WORD_W-1:0] elem_rd(input logic [1:0] ew, input logic [1:0] off,
                                                 input logic [WORD_W-1:0] w, input logic sx);
    logic [WORD_W-1:0] sh;
    case (ew)
      2'd0: begin
        sh = w >> {off, 3'b000};
        return sx ? {{24{sh[7]}}, sh[7:0]} : {24'b0, sh[7:0]};
      end
      2'd1: begin
        sh = w >> {off[1], 4'b0000};
        return sx ? {{16{sh[15]}}, sh[15:0]} : {16'b0, sh[15:0]};
      end
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/vmau_fifo.sv
module vmau_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  assign dout  = mem[rp[PW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
endmodule

// File: rtl/vmau_agen.sv
module vmau_agen
  import vmau_pkg::*;
#(
  parameter int NLANES = 16,
  parameter int MLANES = 4,
  parameter int GW     = 3,
  parameter int VLW    = 5
) (
  input  logic [GW-1:0]            grp,
  input  logic [ADDR_W-1:0]        grp_base,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic                     indexed,
  input  logic [1:0]               ew,
  input  logic [VLW-1:0]           vlen,
  input  logic [NLANES*ADDR_W-1:0] idx_flat,
  input  logic [NLANES*WORD_W-1:0] wd_flat,
  output logic [MLANES-1:0]        mask,
  output logic [MLANES*ADDR_W-1:0] addr_flat,
  output logic [MLANES*BE_W-1:0]   be_flat,
  output logic [MLANES*WORD_W-1:0] wdata_flat
);
  for (genvar s = 0; s < MLANES; s++) begin : g_slot
    logic [ADDR_W-1:0] idx_sel, a;
    logic [WORD_W-1:0] wd_sel;

    // write crossbar / index select: lane owning this slot's element
    always_comb begin
      idx_sel = '0;
      wd_sel  = '0;
      for (int j = 0; j < NLANES; j++) begin
        if (j == int'(grp) * MLANES + s) begin
          idx_sel = idx_flat[j*ADDR_W +: ADDR_W];
          wd_sel  = wd_flat[j*WORD_W +: WORD_W];
        end
      end
    end

    assign a = indexed ? (base + idx_sel) : (grp_base + stride * ADDR_W'(s));
    assign mask[s] = (int'(grp) * MLANES + s) < int'(vlen);
    assign addr_flat[s*ADDR_W +: ADDR_W] = a;
    assign be_flat[s*BE_W +: BE_W]       = elem_be(ew, a[1:0]);
    assign wdata_flat[s*WORD_W +: WORD_W] = elem_wr(ew, wd_sel);
  end
endmodule

// File: rtl/vmau_rxbar.sv
module vmau_rxbar
  import vmau_pkg::*;
#(
  parameter int NLANES = 16,
  parameter int MLANES = 4,
  parameter int GW     = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     resp_valid,
  input  logic [MLANES*WORD_W-1:0] resp_data_flat,
  input  logic [GW-1:0]            resp_grp,
  input  logic [MLANES-1:0]        resp_mask,
  input  logic [MLANES*2-1:0]      resp_off_flat,
  input  logic [1:0]               ew,
  input  logic                     sext,
  output logic [NLANES-1:0]        rd_valid,
  output logic [NLANES*WORD_W-1:0] rd_data_flat
);
  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    localparam int SL = j % MLANES;
    localparam int GJ = j / MLANES;
    logic              hit, v_q;
    logic [WORD_W-1:0] d_q;

    assign hit = resp_valid && (int'(resp_grp) == GJ) && resp_mask[SL];

    always_ff @(posedge clk) begin
      if (rst)       v_q <= 1'b0;
      else if (clr)  v_q <= 1'b0;
      else if (hit)  v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit)
        d_q <= elem_rd(ew, resp_off_flat[SL*2 +: 2], resp_data_flat[SL*WORD_W +: WORD_W], sext);
    end

    assign rd_valid[j] = v_q;
    assign rd_data_flat[j*WORD_W +: WORD_W] = d_q;
  end
endmodule

// File: rtl/vmem_addr_unit.sv
module vmem_addr_unit
  import vmau_pkg::*;
#(
  parameter  int NLANES = 16,
  parameter  int MLANES = 4,
  parameter  int QDEPTH = 4,
  localparam int VLW    = $clog2(NLANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     is_store,
  input  logic                     indexed,
  input  logic [1:0]               ew,
  input  logic                     sext,
  input  logic [VLW-1:0]           vlen,
  input  logic [31:0]              base,
  input  logic [31:0]              stride,
  input  logic [NLANES*32-1:0]     idx_flat,
  input  logic [NLANES*32-1:0]     wdata_flat,
  output logic                     busy,
  output logic                     creq_valid,
  input  logic                     creq_ready,
  output logic                     creq_write,
  output logic [MLANES-1:0]        creq_mask,
  output logic [MLANES*32-1:0]     creq_addr_flat,
  output logic [MLANES*4-1:0]      creq_be_flat,
  output logic [MLANES*32-1:0]     creq_wdata_flat,
  input  logic                     cresp_valid,
  input  logic [MLANES*32-1:0]     cresp_data_flat,
  output logic [NLANES-1:0]        rd_valid,
  output logic [NLANES*32-1:0]     rd_data_flat
);
  localparam int NGRP = (NLANES + MLANES - 1) / MLANES;
  localparam int GW   = $clog2(NGRP + 1);
  localparam int RQW  = GW + MLANES + MLANES*ADDR_W + MLANES*BE_W;
  localparam int WQW  = MLANES*WORD_W;
  localparam int TKW  = GW + MLANES + MLANES*2;

  // latched instruction
  logic                     st_r, ix_r, sx_r;
  logic [1:0]               ew_r;
  logic [VLW-1:0]           vl_r;
  logic [ADDR_W-1:0]        base_r, stride_r, gbase;
  logic [NLANES*ADDR_W-1:0] idx_r;
  logic [NLANES*WORD_W-1:0] wd_r;
  logic [GW-1:0]            grp;

  logic accept, issue_done;
  assign accept     = start && !busy;
  assign issue_done = int'(grp) * MLANES >= int'(vl_r);

  // address generation and write steering for the current group
  logic [MLANES-1:0]        g_mask;
  logic [MLANES*ADDR_W-1:0] g_addr;
  logic [MLANES*BE_W-1:0]   g_be;
  logic [MLANES*WORD_W-1:0] g_wd;

  vmau_agen #(.NLANES(NLANES), .MLANES(MLANES), .GW(GW), .VLW(VLW)) u_agen (
    .grp(grp), .grp_base(gbase), .base(base_r), .stride(stride_r),
    .indexed(ix_r), .ew(ew_r), .vlen(vl_r), .idx_flat(idx_r), .wd_flat(wd_r),
    .mask(g_mask), .addr_flat(g_addr), .be_flat(g_be), .wdata_flat(g_wd)
  );

  // request and write queues
  logic           rq_full, rq_empty, wq_full, wq_empty;
  logic           rq_push, rq_pop;
  logic [RQW-1:0] rq_dout;
  logic [WQW-1:0] wq_dout;

  assign rq_push = busy && !issue_done && !rq_full && !wq_full;

  vmau_fifo #(.W(RQW), .DEPTH(QDEPTH)) u_reqq (
    .clk(clk), .rst(rst), .push(rq_push), .din({grp, g_mask, g_addr, g_be}),
    .pop(rq_pop), .dout(rq_dout), .empty(rq_empty), .full(rq_full)
  );

  vmau_fifo #(.W(WQW), .DEPTH(QDEPTH)) u_wrq (
    .clk(clk), .rst(rst), .push(rq_push && st_r), .din(g_wd),
    .pop(rq_pop && st_r), .dout(wq_dout), .empty(wq_empty), .full(wq_full)
  );

  logic [GW-1:0]            h_grp;
  logic [MLANES-1:0]        h_mask;
  logic [MLANES*ADDR_W-1:0] h_addr;
  logic [MLANES*BE_W-1:0]   h_be;
  logic [MLANES*2-1:0]      h_off;
  assign {h_grp, h_mask, h_addr, h_be} = rq_dout;

  for (genvar s = 0; s < MLANES; s++) begin : g_off
    assign h_off[s*2 +: 2] = h_addr[s*ADDR_W +: 2];
  end

  // outstanding-load tracker
  logic           tk_full, tk_empty;
  logic [TKW-1:0] tk_dout;
  logic [GW-1:0]  t_grp;
  logic [MLANES-1:0]   t_mask;
  logic [MLANES*2-1:0] t_off;

  assign creq_valid      = !rq_empty && (st_r || !tk_full);
  assign rq_pop          = creq_valid && creq_ready;
  assign creq_write      = st_r;
  assign creq_mask       = h_mask;
  assign creq_addr_flat  = h_addr;
  assign creq_be_flat    = h_be;
  assign creq_wdata_flat = wq_dout;

  vmau_fifo #(.W(TKW), .DEPTH(QDEPTH)) u_trk (
    .clk(clk), .rst(rst), .push(rq_pop && !st_r), .din({h_grp, h_mask, h_off}),
    .pop(cresp_valid), .dout(tk_dout), .empty(tk_empty), .full(tk_full)
  );
  assign {t_grp, t_mask, t_off} = tk_dout;

  vmau_rxbar #(.NLANES(NLANES), .MLANES(MLANES), .GW(GW)) u_rxbar (
    .clk(clk), .rst(rst), .clr(accept), .resp_valid(cresp_valid && !tk_empty),
    .resp_data_flat(cresp_data_flat), .resp_grp(t_grp), .resp_mask(t_mask),
    .resp_off_flat(t_off), .ew(ew_r), .sext(sx_r),
    .rd_valid(rd_valid), .rd_data_flat(rd_data_flat)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      grp  <= '0;
    end else if (busy) begin
      if (rq_push) grp <= grp + 1'b1;
      if (issue_done && rq_empty && tk_empty) busy <= 1'b0;
    end
  end

  // instruction and running strided base (no reset needed)
  always_ff @(posedge clk) begin
    if (accept) begin
      st_r     <= is_store;
      ix_r     <= indexed;
      sx_r     <= sext;
      ew_r     <= ew;
      vl_r     <= vlen;
      base_r   <= base;
      stride_r <= stride;
      gbase    <= base;
      idx_r    <= idx_flat;
      wd_r     <= wdata_flat;
    end else if (rq_push) begin
      gbase <= gbase + stride_r * ADDR_W'(MLANES);
    end
  end
endmodule

// File: rtl/vmem_addr_unit_chk.sv
module vmem_addr_unit_chk #(
  parameter int NLANES = 16,
  parameter int MLANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 creq_valid,
  input logic                 creq_ready,
  input logic                 creq_write,
  input logic [MLANES-1:0]    creq_mask,
  input logic [MLANES*32-1:0] creq_addr_flat,
  input logic [MLANES*4-1:0]  creq_be_flat,
  input logic [NLANES-1:0]    rd_valid
);
  // R6: a stalled request keeps its payload
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    creq_valid && !creq_ready |=> creq_valid && $stable(creq_addr_flat)
      && $stable(creq_mask) && $stable(creq_be_flat) && $stable(creq_write));

  // R3: active slots form a prefix starting at slot 0
  assert_mask_prefix_R3: assert property (@(posedge clk) disable iff (rst)
    creq_valid |-> creq_mask[0] && ((creq_mask & (creq_mask + 1'b1)) == '0));

  // R4: slot 0 is always active and so must enable at least one byte
  assert_be_active_R4: assert property (@(posedge clk) disable iff (rst)
    creq_valid |-> creq_be_flat[3:0] != 4'b0000);

  // R7: nothing is requested while idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !creq_valid);

  // R7: an accepted start raises busy and clears the lane flags
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && (rd_valid == '0));

  // R5: lane flags only change during an instruction or at its start
  assert_rd_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(rd_valid));
endmodule

bind vmem_addr_unit vmem_addr_unit_chk #(.NLANES(NLANES), .MLANES(MLANES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .creq_valid(creq_valid),
  .creq_ready(creq_ready), .creq_write(creq_write), .creq_mask(creq_mask),
  .creq_addr_flat(creq_addr_flat), .creq_be_flat(creq_be_flat), .rd_valid(rd_valid)
);

// File: tb/test_vmem_addr_unit.sv
module test_vmem_addr_unit;
  localparam int NL = 16;
  localparam int ML = 4;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic start = 0, is_store = 0, indexed = 0, sext = 0;
  logic [1:0] ew = 2;
  logic [4:0] vlen = 0;
  logic [31:0] base = 0, stride = 0;
  logic [NL*32-1:0] idx_flat = '0, wdata_flat = '0;
  logic busy, creq_valid, creq_write;
  logic creq_ready = 1;
  logic [ML-1:0] creq_mask;
  logic [ML*32-1:0] creq_addr_flat, creq_wdata_flat;
  logic [ML*4-1:0] creq_be_flat;
  logic cresp_valid = 0;
  logic [ML*32-1:0] cresp_data_flat = '0;
  logic [NL-1:0] rd_valid;
  logic [NL*32-1:0] rd_data_flat;

  vmem_addr_unit #(.NLANES(NL), .MLANES(ML), .QDEPTH(4)) i_vmem_addr_unit (.*);

  int n_run = 0, n_fail = 0;

  typedef struct packed {
    logic wr;
    logic [ML-1:0] mask;
    logic [ML*32-1:0] addr;
    logic [ML*4-1:0] be;
    logic [ML*32-1:0] wd;
  } req_t;

  req_t exp_q[$];
  logic [ML*32-1:0] rsp_q[$];
  int rsp_t[$];
  logic [31:0] idx_a [NL];
  logic [31:0] wd_a [NL];
  logic [31:0] lane_exp [NL];
  int stall_mode = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ 32'h5A0FC3A5;
  endfunction

  function automatic logic [3:0] be_of(input logic [1:0] e, input logic [1:0] o);
    if (e == 0) return 4'b0001 << o;
    if (e == 1) return o[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] wr_of(input logic [1:0] e, input logic [31:0] d);
    if (e == 0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (e == 1) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] rd_of(input logic [1:0] e, input logic [1:0] o,
                                        input logic [31:0] w, input logic sx);
    logic [7:0] b;
    logic [15:0] h;
    b = w[8*o +: 8];
    h = o[1] ? w[31:16] : w[15:0];
    if (e == 0) return sx ? {{24{b[7]}}, b} : {24'h0, b};
    if (e == 1) return sx ? {{16{h[15]}}, h} : {16'h0, h};
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cache model and monitor
  always begin
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    creq_ready = (stall_mode == 0) ? 1'b1 : (stall_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
    if (rsp_q.size() > 0 && rsp_t[0] <= cyc) begin
      cresp_valid = 1;
      cresp_data_flat = rsp_q.pop_front();
      void'(rsp_t.pop_front());
    end else begin
      cresp_valid = 0;
    end
    #1;
    if (creq_valid && creq_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R6", "unexpected extra request", creq_addr_flat, 0);
      end else begin
        req_t e;
        logic [ML*32-1:0] rd;
        bit ok;
        e = exp_q.pop_front();
        ok = (creq_write == e.wr) && (creq_mask == e.mask);
        rd = '0;
        for (int s = 0; s < ML; s++) begin
          if (e.mask[s]) begin
            ok &= creq_addr_flat[s*32 +: 32] == e.addr[s*32 +: 32];
            ok &= creq_be_flat[s*4 +: 4] == e.be[s*4 +: 4];
            if (e.wr) ok &= creq_wdata_flat[s*32 +: 32] == e.wd[s*32 +: 32];
            rd[s*32 +: 32] = memfn(creq_addr_flat[s*32 +: 32]);
          end
        end
        check(ok, "R1/R2/R3/R4", "request group (addr)", creq_addr_flat, e.addr);
        if (!ok) $display("      mask act=%b exp=%b be act=%h exp=%h", creq_mask, e.mask, creq_be_flat, e.be);
        if (!creq_write) begin
          rsp_q.push_back(rd);
          rsp_t.push_back(cyc + 2);
        end
      end
    end
  end

  task automatic run_op(input logic st, input logic ix, input logic [1:0] e_w, input logic sx,
                        input int vl, input logic [31:0] b, input logic [31:0] sd, input bit junk);
    req_t r;
    int el, t;
    logic [31:0] a;
    for (int g = 0; g * ML < vl; g++) begin
      r = '0;
      r.wr = st;
      for (int s = 0; s < ML; s++) begin
        el = g * ML + s;
        if (el < vl) begin
          a = ix ? b + idx_a[el] : b + sd * 32'(el);
          r.mask[s] = 1'b1;
          r.addr[s*32 +: 32] = a;
          r.be[s*4 +: 4] = be_of(e_w, a[1:0]);
          r.wd[s*32 +: 32] = wr_of(e_w, wd_a[el]);
          lane_exp[el] = rd_of(e_w, a[1:0], memfn(a), sx);
        end
      end
      exp_q.push_back(r);
    end
    @(negedge clk);
    is_store = st; indexed = ix; ew = e_w; sext = sx; vlen = 5'(vl); base = b; stride = sd;
    for (int j = 0; j < NL; j++) begin
      idx_flat[j*32 +: 32] = idx_a[j];
      wdata_flat[j*32 +: 32] = wd_a[j];
    end
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R7", "busy after start", busy, 1);
    check(rd_valid === '0, "R7", "rd_valid cleared at start", rd_valid, 0);
    if (junk) begin
      base = 32'hDEAD0000; vlen = 5'd3; is_store = ~st;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (busy === 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    #2;
    check(t < 5000, "R7", "busy falls at end", busy, 0);
    check(exp_q.size() == 0, "R6", "all groups delivered once", exp_q.size(), 0);
    if (!st) begin
      for (int j = 0; j < NL; j++) begin
        if (j < vl) begin
          check(rd_valid[j] === 1'b1, "R5", $sformatf("lane %0d valid", j), rd_valid[j], 1);
          check(rd_data_flat[j*32 +: 32] === lane_exp[j], "R5", $sformatf("lane %0d data", j),
                rd_data_flat[j*32 +: 32], lane_exp[j]);
        end else begin
          check(rd_valid[j] === 1'b0, "R5", $sformatf("lane %0d beyond vlen", j), rd_valid[j], 0);
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog: run hung, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int j = 0; j < NL; j++) begin
      idx_a[j] = 32'(j * 37 + (j % 4));
      wd_a[j]  = 32'hC0DE0000 + 32'(j * 32'h1111) + 32'(j * 3);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy === 0, "R9", "busy after reset", busy, 0);
    check(creq_valid === 0, "R9", "creq_valid after reset", creq_valid, 0);
    check(rd_valid === '0, "R9", "rd_valid after reset", rd_valid, 0);

    // R1 R3 R5: unit-stride word load, full length
    run_op(0, 0, 2, 0, 16, 32'h0000_1000, 32'd4, 0);
    // R1 R3 R4 R6: strided word store, partial last group, random stalls
    stall_mode = 1;
    run_op(1, 0, 2, 0, 7, 32'h0000_2000, 32'd12, 0);
    // R2 R5: indexed byte loads, sign and zero extension
    run_op(0, 1, 0, 1, 5, 32'h0000_3001, 32'd0, 0);
    run_op(0, 1, 0, 0, 5, 32'h0000_3001, 32'd0, 0);
    // R2 R4: indexed halfword store
    for (int j = 0; j < NL; j++) idx_a[j] = 32'(j * 6);
    run_op(1, 1, 1, 0, 10, 32'h0000_4000, 32'd0, 0);
    // R1 R5: negative stride halfword load, sign extension
    run_op(0, 0, 1, 1, 9, 32'h0000_5010, 32'hFFFF_FFFE, 0);
    // R4: byte store, stride 1
    run_op(1, 0, 0, 0, 13, 32'h0000_6003, 32'd1, 0);
    // R6 R7: long stall with an ignored start while busy
    stall_mode = 2;
    fork
      run_op(0, 0, 2, 0, 16, 32'h0000_7000, 32'd8, 1);
      begin
        repeat (30) @(negedge clk);
        stall_mode = 1;
      end
    join
    // R8: zero-length instruction
    stall_mode = 0;
    run_op(0, 0, 2, 0, 0, 32'h0000_8000, 32'd4, 0);
    @(negedge clk);
    check(busy === 0 && creq_valid === 0, "R8", "zero length idle", busy, 0);
    check(rd_valid === '0, "R8", "zero length leaves lanes invalid", rd_valid, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule